// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management cycles to an external PHY on behalf of a host that sees four word-wide registers. The host loads a PHY address, a register number and an operation into one register. For a write it also loads sixteen bits of data into a second register. It then sets the start bit in the control register. The block divides the system clock down to MDC and sends the complete frame on the shared MDIO line. On a read it releases the line so the PHY can answer, and it stores the sixteen returned bits in a read-only register.

The start bit also serves as the busy flag. The host polls it until it drops to 0, which happens a fixed 64 MDC periods after the start, well inside any millisecond-scale software timeout. An enable bit in the control register gates the interface: a start request is honoured only when the same control write also sets enable. The host bus is a plain single-cycle register port with combinational readback and no handshake, because every access completes in one cycle. MDIO is split into output, output-enable and input pins, and the pad tristate is built outside the block.

Top module: `mdio_master`

## Requirements
- R1: Register words are selected by `host_addr`. Word 0 holds the PHY register number in bits 4:0, the PHY address in bits 9:5 and the operation in bit 10 (1 = read, 0 = write). Word 1 holds the write data in bits 15:0. Word 2 is the read result in bits 15:0 and ignores writes. Word 3 is control, with bit 0 as start/busy and bit 3 as enable. Every other bit reads 0, and all registers reset to 0.
- R2: A write frame is sent MSB first on MDC rising-edge sample points as: 32 ones, start 01, opcode 01, 5 PHY address bits, 5 register bits, turnaround 10, then the 16 write data bits.
- R3: A read frame sends 32 ones, 01, opcode 10, the PHY address and the register number. It then samples 16 data bits from `mdio_i`, MSB first, and places them in word 2 once the frame ends.
- R4: A control write with bit 0 set and bit 3 clear starts nothing: busy stays 0 and MDC does not toggle.
- R5: Busy reads 1 from the cycle after the starting write until exactly 64 MDC periods later, which is 128 × HALF_DIV system clocks.
- R6: During a read, `mdio_oe` is low from the first turnaround bit to the end of the frame. During a write, and for the whole read header, it is high.
- R7: The master changes `mdio_o` and `mdio_oe` only at MDC falling edges (or at the start of a frame while MDC is low). It samples `mdio_i` at MDC rising edges.
- R8: MDC has a period of 2 × HALF_DIV system clocks, where HALF_DIV is the smallest value that keeps MDC at or below MDC_MAX_HZ. MDC stays low whenever no frame is active.
- R9: Any host write made while busy is discarded, to every register including control.
- R10: A write transaction leaves the read result register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 2 | Register word select |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Combinational readback of the selected word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO driver enable, 0 releases the line |

## Verification
The bench sends frames that differ in operation, PHY address and register number. This separates a correct field order from swapped or shifted fields, and it separates a correct opcode from a swapped one. The read values 0xA5C3, 0x0001 and the extreme addresses 0 and 31 expose bit-order errors and off-by-one sampling errors. A single set bit shows whether the last sample lands at the final rising edge. A model PHY drives the turnaround 0 and the data on falling edges, so the master's release timing and its sampling edge both show in the result. Disabled starts, writes made while busy, and a write that follows a read check that side effects stay where the requirements put them.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int DATA_W     = 16;
  localparam int FIELD_W    = 5;
  localparam int BUS_W      = 32;

  localparam int CTRL_GO_BIT = 0;
  localparam int CTRL_EN_BIT = 3;
  localparam int OP_BIT      = 10;

  typedef enum logic [1:0] {
    RW_LOC   = 2'd0,
    RW_WDATA = 2'd1,
    RW_RDATA = 2'd2,
    RW_CTRL  = 2'd3
  } reg_word_e;

  typedef struct packed {
    logic               rd;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regno;
    logic [DATA_W-1:0]  wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_result,
  output logic              start,
  output mdio_cmd_t         cmd
);
  localparam int LOC_W = OP_BIT + 1;

  logic [LOC_W-1:0]  loc_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;
  logic              en_q;
  logic              wr_ok;
  reg_word_e         sel;
  logic              unused_hi;

  assign sel       = reg_word_e'(host_addr);
  assign wr_ok     = host_we & ~busy;
  assign unused_hi = ^host_wdata[BUS_W-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
      en_q  <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (sel)
          RW_LOC:   loc_q <= host_wdata[LOC_W-1:0];
          RW_WDATA: wd_q  <= host_wdata[DATA_W-1:0];
          RW_CTRL:  en_q  <= host_wdata[CTRL_EN_BIT];
          default:  ;
        endcase
      end
      if (rd_done) rd_q <= rd_result;
    end
  end

  assign start = wr_ok && (sel == RW_CTRL) &&
                 host_wdata[CTRL_GO_BIT] && host_wdata[CTRL_EN_BIT];

  always_comb begin
    host_rdata = '0;
    case (sel)
      RW_LOC:   host_rdata[LOC_W-1:0]  = loc_q;
      RW_WDATA: host_rdata[DATA_W-1:0] = wd_q;
      RW_RDATA: host_rdata[DATA_W-1:0] = rd_q;
      RW_CTRL: begin
        host_rdata[CTRL_GO_BIT] = busy;
        host_rdata[CTRL_EN_BIT] = en_q;
      end
      default: ;
    endcase
  end

  assign cmd.rd    = loc_q[OP_BIT];
  assign cmd.phy   = loc_q[2*FIELD_W-1:FIELD_W];
  assign cmd.regno = loc_q[FIELD_W-1:0];
  assign cmd.wdata = wd_q;
endmodule

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == LAST);
  assign rise_stb = wrap & ~mdc;
  assign fall_stb = wrap & mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam logic [6:0] LAST_IDX = 7'(FRAME_BITS - 1);
  localparam logic [6:0] TA_IDX   = 7'(TA_POS);
  localparam logic [6:0] DAT_IDX  = 7'(DATA_POS);

  logic [FRAME_BITS-1:0] frame_sr;
  logic [FRAME_BITS-1:0] frame_new;
  logic [6:0]            bit_idx;
  logic                  is_rd;
  logic [DATA_W-1:0]     rd_sh;
  logic                  released;

  assign frame_new = {{PRE_BITS{1'b1}}, 2'b01,
                      cmd.rd ? 2'b10 : 2'b01,
                      cmd.phy, cmd.regno, 2'b10,
                      cmd.rd ? {DATA_W{1'b0}} : cmd.wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_sr <= '0;
      bit_idx  <= '0;
      is_rd    <= 1'b0;
      rd_sh    <= '0;
      busy     <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        frame_sr <= frame_new;
        bit_idx  <= '0;
        is_rd    <= cmd.rd;
        busy     <= 1'b1;
      end
    end else begin
      if (rise_stb && is_rd && bit_idx >= DAT_IDX)
        rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        frame_sr <= {frame_sr[FRAME_BITS-2:0], 1'b0};
        bit_idx  <= bit_idx + 1'b1;
        if (bit_idx == LAST_IDX) busy <= 1'b0;
      end
    end
  end

  assign released = is_rd && (bit_idx >= TA_IDX);
  assign mdio_oe  = busy & ~released;
  assign mdio_o   = mdio_oe ? frame_sr[FRAME_BITS-1] : 1'b1;
  assign rd_done  = busy & fall_stb & is_rd & (bit_idx == LAST_IDX);
  assign rd_data  = rd_sh;
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int MDC_MAX_HZ = 2_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int HALF_RAW = (CLK_HZ + 2*MDC_MAX_HZ - 1) / (2*MDC_MAX_HZ);
  localparam int HALF_DIV = (HALF_RAW < 1) ? 1 : HALF_RAW;

  logic              busy_w;
  logic              start_w;
  logic              rd_done_w;
  logic [DATA_W-1:0] rd_data_w;
  logic              rise_w;
  logic              fall_w;
  mdio_cmd_t         cmd_w;

  mdio_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy       (busy_w),
    .rd_done    (rd_done_w),
    .rd_result  (rd_data_w),
    .start      (start_w),
    .cmd        (cmd_w)
  );

  mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_w),
    .mdc      (mdc),
    .rise_stb (rise_w),
    .fall_stb (fall_w)
  );

  mdio_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .cmd      (cmd_w),
    .rise_stb (rise_w),
    .fall_stb (fall_w),
    .mdio_i   (mdio_i),
    .busy     (busy_w),
    .rd_done  (rd_done_w),
    .rd_data  (rd_data_w),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       rd_op,
  input logic       host_we,
  input logic [1:0] host_addr,
  input logic       wr_en_bit
);
  logic       mdc_q;
  logic [6:0] fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      fcnt  <= '0;
    end else begin
      mdc_q <= mdc;
      if (!busy) fcnt <= '0;
      else if (mdc_q && !mdc) fcnt <= fcnt + 1'b1;
    end
  end

  // R8: clock idle low
  a_r8_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R4: disabled start leaves the block idle
  a_r4_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == 2'd3 && !wr_en_bit && !busy) |=> !busy);

  // R7: line only moves while MDC is low
  a_r7_steady_mdc_high: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R5: busy ends on the 64th falling edge
  a_r5_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (fcnt == 7'd63 && $fell(mdc)));

  // R6: line released for turnaround and data on reads
  a_r6_release_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_op && fcnt >= 7'd47) |-> !mdio_oe);

  // R6: header always driven
  a_r6_drive_header: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fcnt < 7'd45) |-> mdio_oe);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_w),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .rd_op     (cmd_w.rd),
  .host_we   (host_we),
  .host_addr (host_addr),
  .wr_en_bit (host_wdata[3])
);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  localparam int HALF     = (50_000_000 + 5_000_000 - 1) / 5_000_000;
  localparam int BUSY_CYC = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_oe = 1'b0;
  logic        phy_o = 1'b1;

  always #10 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int tests = 0;
  int fails = 0;

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [63:0] bits;
    logic [63:0] oe;
  } item_t;
  item_t exp_q[$];

  int          phy_cnt = 0;
  logic        phy_rd = 1'b0;
  logic [15:0] phy_val = '0;
  logic [63:0] cap_bits = '0;
  logic [63:0] cap_oe = '0;
  int          mdc_rises = 0;
  time         last_rise = 0;
  time         mdc_per = 0;

  // monitor: samples the line like a PHY and scores each finished frame
  always @(posedge mdc) begin
    item_t e;
    mdc_per = $time - last_rise;
    last_rise = $time;
    mdc_rises++;
    if (mdio_oe && phy_oe) check_eq("R6", "bus contention", 64'd1, 64'd0);
    cap_bits = {cap_bits[62:0], mdio_i};
    cap_oe   = {cap_oe[62:0], mdio_oe};
    phy_cnt++;
    if (phy_cnt == 36) phy_rd = (cap_bits[1:0] == 2'b10);
    if (phy_cnt == 64) begin
      if (exp_q.size() == 0) check_eq("R2", "unexpected frame", 64'd1, 64'd0);
      else begin
        e = exp_q.pop_front();
        check_eq("R2/R3", "frame bits", cap_bits, e.bits);
        check_eq("R6", "drive mask", cap_oe, e.oe);
      end
    end
  end

  // PHY answer on reads: turnaround 0 then data, changed on falling MDC (R7)
  always @(negedge mdc) begin
    if (phy_rd && phy_cnt >= 47 && phy_cnt <= 63) begin
      phy_oe = 1'b1;
      phy_o  = (phy_cnt == 47) ? 1'b0 : phy_val[63 - phy_cnt];
    end else begin
      phy_oe = 1'b0;
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic xfer(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] wd, input logic [15:0] pv, input bit meddle);
    item_t e;
    logic [31:0] v;
    int n;
    reg_write(2'd0, {21'd0, rd, phy, rg});
    reg_write(2'd1, {16'd0, wd});
    phy_val = pv; phy_cnt = 0; phy_rd = 1'b0;
    e.bits = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, rd ? pv : wd};
    e.oe   = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    exp_q.push_back(e);
    reg_write(2'd3, 32'h9);
    n = 0;
    reg_read(2'd3, v);
    while (v[0] && n < 5000) begin
      n++;
      @(negedge clk);
      host_we = 1'b0;
      reg_read(2'd3, v);
      if (meddle && n == 200) begin host_we = 1'b1; host_addr = 2'd0; host_wdata = 32'h0; end
      if (meddle && n == 201) begin host_we = 1'b1; host_addr = 2'd1; host_wdata = 32'h5555; end
      if (meddle && n == 202) begin host_we = 1'b1; host_addr = 2'd3; host_wdata = 32'h1; end
    end
    host_we = 1'b0;
    check_eq("R5", "busy cycles", 64'(n), 64'(BUSY_CYC));
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R8 idle clock
    for (int i = 0; i < 4; i++) begin
      reg_read(2'(i), v);
      check_eq("R1", "reset word", 64'(v), 64'd0);
    end
    check_eq("R8", "mdc idle after reset", 64'(mdc), 64'd0);
    check_eq("R6", "oe idle after reset", 64'(mdio_oe), 64'd0);

    // R1 field widths and read-only result word
    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_read(2'd0, v); check_eq("R1", "location word", 64'(v), 64'h7FF);
    reg_write(2'd1, 32'h1234_ABCD);
    reg_read(2'd1, v); check_eq("R1", "write data word", 64'(v), 64'hABCD);
    reg_write(2'd2, 32'hFFFF_FFFF);
    reg_read(2'd2, v); check_eq("R1", "result word read-only", 64'(v), 64'd0);
    reg_write(2'd3, 32'h8);
    reg_read(2'd3, v); check_eq("R1", "control enable only", 64'(v), 64'h8);

    // R4 start without enable
    r0 = mdc_rises;
    reg_write(2'd3, 32'h1);
    reg_read(2'd3, v); check_eq("R4", "control after disabled start", 64'(v), 64'd0);
    repeat (100) @(negedge clk);
    check_eq("R4", "mdc rises while disabled", 64'(mdc_rises - r0), 64'd0);
    check_eq("R4", "no frame queued", 64'(exp_q.size()), 64'd0);

    // R2 write frame, R8 period, R10 result untouched
    xfer(1'b0, 5'h13, 5'h0A, 16'hBEEF, 16'h0, 1'b0);
    check_eq("R8", "mdc period ns", 64'(mdc_per), 64'(2 * HALF * 20));
    check_eq("R8", "mdc low after frame", 64'(mdc), 64'd0);
    reg_read(2'd2, v); check_eq("R10", "result after write", 64'(v), 64'd0);

    // R3 reads with distinct patterns, R7 sampling edge
    xfer(1'b1, 5'h01, 5'h02, 16'h0, 16'hA5C3, 1'b0);
    reg_read(2'd2, v); check_eq("R3", "read result A5C3", 64'(v), 64'hA5C3);
    xfer(1'b1, 5'h1F, 5'h1F, 16'h0, 16'h0001, 1'b0);
    reg_read(2'd2, v); check_eq("R7", "read result lsb", 64'(v), 64'h0001);

    // R10 write after read keeps result
    xfer(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0, 1'b0);
    reg_read(2'd2, v); check_eq("R10", "result kept", 64'(v), 64'h0001);

    // R9 writes during busy discarded
    xfer(1'b0, 5'h0C, 5'h15, 16'h3C3C, 16'h0, 1'b1);
    reg_read(2'd0, v); check_eq("R9", "location kept", 64'(v), 64'h195);
    reg_read(2'd1, v); check_eq("R9", "write data kept", 64'(v), 64'h3C3C);
    reg_read(2'd3, v); check_eq("R9", "control kept", 64'(v), 64'h8);

    repeat (50) @(negedge clk);
    check_eq("R2", "all frames seen", 64'(exp_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule